// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external bus timing for a small 8-bit controller core. That core shares one byte-wide port between the low address byte and the data byte. The oscillator clock is split into machine cycles of `CYC_LEN` periods, twelve by default. Near the end of each machine cycle the core presents one request. The request is one of three kinds: an opcode fetch, an external data read, or an external data write. A data request also gives its address width. The request is captured at the boundary, and during the next machine cycle the sequencer drives these signals from that single captured request:

- the address-latch strobe
- the code-read strobe
- the data read and data write strobes
- the multiplexed low-byte lane
- the high-address byte

An opcode fetch reads two consecutive code bytes, one in each half of the machine cycle. For each half, the block decides whether the byte comes from on-chip code or from the external bus. That decision uses an external-access input and a code-address limit. Bytes returned on the lane during external fetches and data reads are captured and handed to the core.

A separate reset qualifier accepts the reset request only once it has stayed high for a whole number of machine cycles, two by default. While the qualified reset is active, all strobes are parked inactive.

Top module: `xbus_seq`

## Requirements
- R1: In a fetch cycle with `latch_quiet` clear, `addr_latch` is high exactly in cycle counts 0, 1, 6 and 7. This gives two 2-clock pulses per machine cycle, one every six clocks.
- R2: In a data read or write cycle, `addr_latch` is high only in counts 0 and 1, so the pulse at counts 6 and 7 is omitted. `code_rd_n` stays high for the whole cycle, so both code-read pulses are skipped.
- R3: When the captured `latch_quiet` is set, `addr_latch` stays low through fetch cycles but still pulses at counts 0 and 1 in data cycles.
- R4: An external fetch drives `code_rd_n` low in counts 3 to 5 for the byte at the request address. It drives `code_rd_n` low again in counts 9 to 11 for the byte at the request address plus one. The matching low address is on `ad_out` with `ad_oe` high in counts 0–1 and 6–7 respectively.
- R5: A fetch half is external when the captured `int_code_en` is 0, or when that half's address is above `INT_CODE_LAST` (0x0FFF). An internal half leaves `code_rd_n` high and `ad_oe` low.
- R6: `hi_addr` carries the address high byte during external fetch halves and during wide (`req_wide`=1) data cycles. It carries the captured `hi_port_reg` during narrow data cycles and during internal fetch halves.
- R7: In data cycles, the low address is driven in counts 0–1. A write drives `req_wdata` from count 2 to count 10, which brackets the write strobe. A read, and a fetch outside its address counts, leaves `ad_oe` low with `ad_out` at 0.
- R8: `data_rd_n` (read, `req_kind`=1) or `data_wr_n` (write, `req_kind`=2) is low in counts 3 to 9 only. Kind 0 and kind 3 are both fetches.
- R9: At the edge that ends count 5 or count 11 of an external fetch half, or count 9 of a read, `ad_in` is captured. It appears on `bus_byte` with a one-cycle `bus_byte_vld` pulse.
- R10: `core_rst` rises after `rst_req` has been sampled high on 24 consecutive edges, and falls one edge after `rst_req` is sampled low. Shorter pulses have no effect. While `core_rst` is high, all strobes are inactive, `ad_oe` is low and `hi_addr` is 0.
- R11: `req_take` is high in count 11 outside reset. The request inputs and `int_code_en`, `latch_quiet` and `hi_port_reg` are sampled at the edge that ends that cycle, and they alone govern the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_req | input | 1 | Reset request, qualified by duration |
| int_code_en | input | 1 | 1: low code space fetched on chip |
| latch_quiet | input | 1 | Suppress address-latch pulses in fetch cycles |
| hi_port_reg | input | 8 | High-port register value |
| req_kind | input | 2 | 0/3 fetch, 1 data read, 2 data write |
| req_wide | input | 1 | Data address is 16 bits |
| req_addr | input | 16 | Fetch or data address |
| req_wdata | input | 8 | Write data |
| ad_in | input | 8 | Byte read back from the lane |
| req_take | output | 1 | Request is sampled at the end of this cycle |
| core_rst | output | 1 | Qualified reset to the core |
| addr_latch | output | 1 | Address-latch strobe, active high |
| code_rd_n | output | 1 | Code-read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Lane output byte |
| ad_oe | output | 1 | Lane output enable |
| hi_addr | output | 8 | High address byte |
| bus_byte | output | 8 | Captured lane byte |
| bus_byte_vld | output | 1 | Captured byte valid pulse |

## Verification
A request sampled while `req_take` is high governs the strobes of the twelve cycles that follow, from count 0 through count 11. Each strobe and lane value is therefore due a fixed number of clocks after that sampling edge. The only exception is the captured byte, which shows one clock after its capture edge.

The qualified reset rises one clock after the 24th consecutive high sample of `rst_req`, and falls one clock after the first low sample. The bench drives inputs and compares every output at the falling edge. It uses a cycle-accurate expectation that advances once per rising edge, so every result is compared in exactly the cycle it is due.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int XB_AW = 16;
  localparam int XB_DW = 8;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              wide;
    logic [XB_AW-1:0]  addr;
    logic [XB_DW-1:0]  wdata;
    logic [XB_DW-1:0]  hi_reg;
    logic              int_en;
    logic              quiet;
  } xreq_t;
endpackage

// File: rtl/xbus_rst_qual.sv
module xbus_rst_qual #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  output logic core_rst
);
  localparam int RW = $clog2(HOLD + 1);
  localparam logic [RW-1:0] FULL = RW'(HOLD);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!rst_req)          cnt_d = '0;
    else if (cnt_q == FULL) cnt_d = FULL;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign core_rst = (cnt_q == FULL);
endmodule

// File: rtl/xbus_timebase.sv
module xbus_timebase
  import xbus_pkg::*;
#(
  parameter int CYC_LEN = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       core_rst,
  input  xreq_t                      req_in,
  output logic [$clog2(CYC_LEN)-1:0] cnt,
  output xreq_t                      cur,
  output logic                       run,
  output logic                       req_take
);
  localparam int CW = $clog2(CYC_LEN);
  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  xreq_t         cur_q, cur_d;
  logic          act_q, act_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    cur_d = cur_q;
    act_d = act_q;
    if (core_rst) begin
      cnt_d = LAST;
      act_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      act_d = 1'b1;
      cur_d = req_in;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LAST;
      act_q <= 1'b0;
      cur_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  assign cnt      = cnt_q;
  assign cur      = cur_q;
  assign run      = act_q && !core_rst;
  assign req_take = wrap && !core_rst && rst_n;
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int                CYC_LEN  = 12,
  parameter logic [XB_AW-1:0]  INT_LAST = 16'h0FFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(CYC_LEN)-1:0] cnt,
  input  xreq_t                      cur,
  input  logic                       run,
  input  logic [XB_DW-1:0]           ad_in,
  output logic                       addr_latch,
  output logic                       code_rd_n,
  output logic                       data_rd_n,
  output logic                       data_wr_n,
  output logic [XB_DW-1:0]           ad_out,
  output logic                       ad_oe,
  output logic [XB_DW-1:0]           hi_addr,
  output logic [XB_DW-1:0]           bus_byte,
  output logic                       bus_byte_vld
);
  localparam int CW = $clog2(CYC_LEN);
  localparam logic [CW-1:0] C_HALF  = CW'(CYC_LEN / 2);
  localparam logic [CW-1:0] C_HALF1 = CW'(CYC_LEN / 2 + 1);
  localparam logic [CW-1:0] C_HEND  = CW'(CYC_LEN / 2 - 1);
  localparam logic [CW-1:0] C_STB0  = CW'(3);
  localparam logic [CW-1:0] C_HSTB0 = CW'(CYC_LEN / 2 + 3);
  localparam logic [CW-1:0] C_LAST  = CW'(CYC_LEN - 1);
  localparam logic [CW-1:0] C_DEND  = CW'(CYC_LEN - 3);
  localparam logic [CW-1:0] C_WEND  = CW'(CYC_LEN - 2);
  localparam logic [CW-1:0] C_ONE   = CW'(1);
  localparam logic [CW-1:0] C_TWO   = CW'(2);

  logic              second, is_fetch, is_rd, is_wr, fetch_ext;
  logic              addr_win, addr_drv, wr_drv, cap;
  logic [XB_AW-1:0]  half_addr;
  logic [XB_DW-1:0]  byte_q, byte_d;
  logic              vld_q;

  assign second    = (cnt >= C_HALF);
  assign half_addr = second ? (cur.addr + 16'd1) : cur.addr;
  assign is_fetch  = (cur.kind == K_FETCH);
  assign is_rd     = (cur.kind == K_READ);
  assign is_wr     = (cur.kind == K_WRITE);
  assign fetch_ext = !cur.int_en || (half_addr > INT_LAST);
  assign addr_win  = (cnt <= C_ONE) || (cnt == C_HALF) || (cnt == C_HALF1);

  always_comb begin
    addr_latch = 1'b0;
    if (run) begin
      if (is_fetch) addr_latch = !cur.quiet && addr_win;
      else          addr_latch = (cnt <= C_ONE);
    end
  end

  assign code_rd_n = !(run && is_fetch && fetch_ext &&
                       (((cnt >= C_STB0) && (cnt <= C_HEND)) || (cnt >= C_HSTB0)));
  assign data_rd_n = !(run && is_rd && (cnt >= C_STB0) && (cnt <= C_DEND));
  assign data_wr_n = !(run && is_wr && (cnt >= C_STB0) && (cnt <= C_DEND));

  assign addr_drv = run && ((is_fetch && fetch_ext && addr_win) ||
                            (!is_fetch && (cnt <= C_ONE)));
  assign wr_drv   = run && is_wr && (cnt >= C_TWO) && (cnt <= C_WEND);

  always_comb begin
    ad_oe  = addr_drv || wr_drv;
    ad_out = '0;
    if (addr_drv)    ad_out = half_addr[XB_DW-1:0];
    else if (wr_drv) ad_out = cur.wdata;
  end

  always_comb begin
    hi_addr = '0;
    if (run) begin
      if (is_fetch) hi_addr = fetch_ext ? half_addr[XB_AW-1:XB_DW] : cur.hi_reg;
      else          hi_addr = cur.wide ? cur.addr[XB_AW-1:XB_DW] : cur.hi_reg;
    end
  end

  assign cap = run && ((is_fetch && fetch_ext && ((cnt == C_HEND) || (cnt == C_LAST))) ||
                       (is_rd && (cnt == C_DEND)));

  always_comb begin
    byte_d = byte_q;
    if (cap) byte_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      byte_q <= byte_d;
      vld_q  <= cap;
    end
  end

  assign bus_byte     = byte_q;
  assign bus_byte_vld = vld_q;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int          CYC_LEN       = 12,
  parameter int          RST_MCYC      = 2,
  parameter logic [15:0] INT_CODE_LAST = 16'h0FFF
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        rst_req,
  input  logic        int_code_en,
  input  logic        latch_quiet,
  input  logic [7:0]  hi_port_reg,
  input  logic [1:0]  req_kind,
  input  logic        req_wide,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic [7:0]  ad_in,
  output logic        req_take,
  output logic        core_rst,
  output logic        addr_latch,
  output logic        code_rd_n,
  output logic        data_rd_n,
  output logic        data_wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  hi_addr,
  output logic [7:0]  bus_byte,
  output logic        bus_byte_vld
);
  localparam int HOLD = RST_MCYC * CYC_LEN;
  localparam int CW   = $clog2(CYC_LEN);

  logic [1:0]    sync_q;
  logic          rst_n_s;
  xreq_t         req_in, cur;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_s = sync_q[1];

  always_comb begin
    req_in.kind   = (req_kind == 2'd3) ? K_FETCH : kind_e'(req_kind);
    req_in.wide   = req_wide;
    req_in.addr   = req_addr;
    req_in.wdata  = req_wdata;
    req_in.hi_reg = hi_port_reg;
    req_in.int_en = int_code_en;
    req_in.quiet  = latch_quiet;
  end

  xbus_rst_qual #(.HOLD(HOLD)) u_rq (
    .clk(clk), .rst_n(rst_n_s), .rst_req(rst_req), .core_rst(core_rst)
  );

  xbus_timebase #(.CYC_LEN(CYC_LEN)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .core_rst(core_rst), .req_in(req_in),
    .cnt(cnt), .cur(cur), .run(run), .req_take(req_take)
  );

  xbus_lane #(.CYC_LEN(CYC_LEN), .INT_LAST(INT_CODE_LAST)) u_ln (
    .clk(clk), .rst_n(rst_n_s), .cnt(cnt), .cur(cur), .run(run), .ad_in(ad_in),
    .addr_latch(addr_latch), .code_rd_n(code_rd_n), .data_rd_n(data_rd_n),
    .data_wr_n(data_wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .bus_byte(bus_byte), .bus_byte_vld(bus_byte_vld)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       core_rst,
  input logic       req_take,
  input logic       addr_latch,
  input logic       code_rd_n,
  input logic       data_rd_n,
  input logic       data_wr_n,
  input logic [7:0] ad_out,
  input logic       ad_oe,
  input logic       bus_byte_vld
);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!data_rd_n || !data_wr_n) |-> (code_rd_n && (data_rd_n || data_wr_n)));

  // R7
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!data_wr_n && $past(!data_wr_n)) |-> ($stable(ad_out) && ad_oe));

  // R7
  rd_lane_free_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !data_rd_n |-> !ad_oe);

  // R1
  latch_width_chk: assert property (@(posedge clk) disable iff (!arst_n || core_rst)
    $rose(addr_latch) |=> addr_latch);

  // R1
  latch_end_chk: assert property (@(posedge clk) disable iff (!arst_n || core_rst)
    (addr_latch && $past(addr_latch)) |=> !addr_latch);

  // R10
  rst_park_chk: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |-> (!addr_latch && code_rd_n && data_rd_n && data_wr_n && !ad_oe));

  // R9
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    bus_byte_vld |=> !bus_byte_vld);

  // R11
  take_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    req_take |=> !req_take);
endmodule

bind xbus_seq xbus_seq_chk u_chk (.*);

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        arst_n, rst_req, int_code_en, latch_quiet, req_wide;
  logic [7:0]  hi_port_reg, req_wdata, ad_in;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic        req_take, core_rst, addr_latch, code_rd_n, data_rd_n, data_wr_n;
  logic [7:0]  ad_out, hi_addr, bus_byte;
  logic        ad_oe, bus_byte_vld;

  always #5 clk = ~clk;

  xbus_seq dut (
    .clk(clk), .arst_n(arst_n), .rst_req(rst_req), .int_code_en(int_code_en),
    .latch_quiet(latch_quiet), .hi_port_reg(hi_port_reg), .req_kind(req_kind),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
    .req_take(req_take), .core_rst(core_rst), .addr_latch(addr_latch),
    .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr), .bus_byte(bus_byte),
    .bus_byte_vld(bus_byte_vld)
  );

  int nvec = 0;
  int nbad = 0;

  // expectation state
  int          m_sync, m_rcnt, m_cnt;
  logic        m_act, m_wide, m_inten, m_quiet, m_vld;
  int          m_kind;
  logic [15:0] m_addr;
  logic [7:0]  m_wdata, m_hi, m_byte;

  // expected outputs
  logic        e_ale, e_crd, e_drd, e_dwr, e_oe, e_cap, e_crst, e_take, e_ext, e_run;
  logic [7:0]  e_ad, e_hi;

  int dir_idx = 99;

  task automatic model_reset();
    m_rcnt = 0; m_cnt = 11; m_act = 1'b0; m_kind = 0; m_wide = 1'b0;
    m_addr = '0; m_wdata = '0; m_hi = '0; m_inten = 1'b0; m_quiet = 1'b0;
    m_vld = 1'b0; m_byte = '0;
  endtask

  task automatic calc();
    logic [15:0] ha;
    logic in_addr;
    e_crst = (m_sync == 2) && (m_rcnt == 24);
    e_run  = (m_sync == 2) && m_act && !e_crst;
    e_take = (m_sync == 2) && (m_cnt == 11) && !e_crst;
    ha     = (m_cnt >= 6) ? m_addr + 16'd1 : m_addr;
    e_ext  = !m_inten || (ha > 16'h0FFF);
    in_addr = (m_cnt <= 1) || (m_cnt == 6) || (m_cnt == 7);
    e_ale = 1'b0; e_crd = 1'b1; e_drd = 1'b1; e_dwr = 1'b1;
    e_oe = 1'b0; e_ad = 8'h00; e_hi = 8'h00; e_cap = 1'b0;
    if (e_run) begin
      if (m_kind == 0) begin
        e_ale = !m_quiet && in_addr;
        if (e_ext) begin
          e_crd = !(((m_cnt >= 3) && (m_cnt <= 5)) || (m_cnt >= 9));
          if (in_addr) begin e_oe = 1'b1; e_ad = ha[7:0]; end
          e_hi  = ha[15:8];
          e_cap = (m_cnt == 5) || (m_cnt == 11);
        end else begin
          e_hi = m_hi;
        end
      end else begin
        e_ale = (m_cnt <= 1);
        e_hi  = m_wide ? m_addr[15:8] : m_hi;
        if (m_cnt <= 1) begin e_oe = 1'b1; e_ad = m_addr[7:0]; end
        if (m_kind == 1) begin
          e_drd = !((m_cnt >= 3) && (m_cnt <= 9));
          e_cap = (m_cnt == 9);
        end else begin
          e_dwr = !((m_cnt >= 3) && (m_cnt <= 9));
          if ((m_cnt >= 2) && (m_cnt <= 10)) begin e_oe = 1'b1; e_ad = m_wdata; end
        end
      end
    end
  endtask

  task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s at %0t: act=%h exp=%h", tag, nm, $time, act, exp);
    end
  endtask

  task automatic compare();
    string t_ale, t_crd;
    nvec++;
    t_ale = !e_run ? "R10" : (m_kind != 0 ? "R2" : (m_quiet ? "R3" : "R1"));
    t_crd = !e_run ? "R10" : (m_kind != 0 ? "R2" : (e_ext ? "R4" : "R5"));
    chk(t_ale, "addr_latch", 16'(addr_latch), 16'(e_ale));
    chk(t_crd, "code_rd_n", 16'(code_rd_n), 16'(e_crd));
    chk("R8", "data_rd_n", 16'(data_rd_n), 16'(e_drd));
    chk("R8", "data_wr_n", 16'(data_wr_n), 16'(e_dwr));
    chk("R7", "ad_oe", 16'(ad_oe), 16'(e_oe));
    chk("R7", "ad_out", 16'(ad_out), 16'(e_ad));
    chk("R6", "hi_addr", 16'(hi_addr), 16'(e_hi));
    chk("R9", "bus_byte_vld", 16'(bus_byte_vld), 16'(m_vld));
    if (m_vld) chk("R9", "bus_byte", 16'(bus_byte), 16'(m_byte));
    chk("R10", "core_rst", 16'(core_rst), 16'(e_crst));
    chk("R11", "req_take", 16'(req_take), 16'(e_take));
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 5)
      0: return 16'h0FFF;
      1: return 16'h1000;
      2: return 16'hFFFF;
      3: return 16'h0FFE;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic drive();
    ad_in = 8'($urandom);
    req_kind = 2'($urandom); req_wide = 1'($urandom); req_addr = pick_addr();
    req_wdata = 8'($urandom); hi_port_reg = 8'($urandom);
    int_code_en = 1'($urandom); latch_quiet = ($urandom % 3) == 0;
    if (dir_idx < 6 && m_sync == 2 && m_cnt == 11 && m_rcnt != 24) begin
      hi_port_reg = 8'h5A; req_wdata = 8'hC3;
      case (dir_idx)
        0: begin req_kind = 2'd0; req_addr = 16'h0FFF; int_code_en = 1; latch_quiet = 0; end // R5 split
        1: begin req_kind = 2'd0; req_addr = 16'h0123; int_code_en = 0; latch_quiet = 1; end // R3
        2: begin req_kind = 2'd2; req_wide = 0; req_addr = 16'h7788; latch_quiet = 1; end    // R6 narrow
        3: begin req_kind = 2'd1; req_wide = 1; req_addr = 16'hABCD; end                     // R6 wide
        4: begin req_kind = 2'd3; req_addr = 16'hFFFF; int_code_en = 1; latch_quiet = 0; end // R4 wrap
        default: begin req_kind = 2'd0; req_addr = 16'h0200; int_code_en = 1; latch_quiet = 0; end // R5 internal
      endcase
      dir_idx++;
    end
  endtask

  task automatic advance();
    logic crst_now;
    if (!arst_n) begin
      m_sync = 0; model_reset();
    end else if (m_sync < 2) begin
      m_sync++; model_reset();
    end else begin
      crst_now = (m_rcnt == 24);
      m_vld = e_cap;
      if (e_cap) m_byte = ad_in;
      m_rcnt = rst_req ? ((m_rcnt == 24) ? 24 : m_rcnt + 1) : 0;
      if (crst_now) begin
        m_cnt = 11; m_act = 1'b0;
      end else if (m_cnt == 11) begin
        m_cnt = 0; m_act = 1'b1;
        m_kind = (req_kind == 2'd3) ? 0 : int'(req_kind);
        m_wide = req_wide; m_addr = req_addr; m_wdata = req_wdata;
        m_hi = hi_port_reg; m_inten = int_code_en; m_quiet = latch_quiet;
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      calc();
      compare();
      drive();
      advance();
      @(negedge clk);
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R11 watchdog: act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    arst_n = 1'b0; rst_req = 1'b0;
    m_sync = 0; model_reset();
    drive();
    @(negedge clk);
    // reset state (R10): checked while arst_n is low
    step(4);
    arst_n = 1'b1;
    step(12 * 40);
    // R10: a pulse of 20 clocks must not reset
    rst_req = 1'b1; step(20); rst_req = 1'b0;
    step(12 * 60);
    // R10: a 30-clock hold qualifies
    rst_req = 1'b1; step(30); rst_req = 1'b0;
    dir_idx = 0;
    step(12 * 10);
    step(12 * 1400);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule